// File: doc/BRIEF.md
# Bus Ownership Hold and Backoff Controller

This block decides, cycle by cycle, who owns a processor's external bus. It watches three ownership requests from the system: a full hold request answered by an acknowledge, an address-only hold used while the system drives a snoop address, and an immediate backoff. From the cycle-start strobe, the ready input and the lock request of the local cycle sequencer, it tracks whether a bus cycle or a locked sequence is running. It drives one output enable for the address lines (with address parity) and another for every other bus driver.

A hold request is honoured only once the bus is quiet: no cycle in flight, no locked sequence open, and no aborted cycle waiting to be replayed. A backoff takes the bus at once. Any cycle in flight is cut off, even one whose ready arrives on the same edge. Its address, byte enables and direction are kept, and the cycle is handed back to the sequencer as a restart once the backoff is released. If a snoop writeback is still pending at that point, the restart waits until the writeback is done. The lock output to the bus is forced low for at least one clock between two locked sequences.

Top module: `bus_own_ctrl`

## Requirements
- R1: After a synchronous reset the block owns the bus: `addrOe`=1, `ctrlOe`=1, `holdAck`=0, `lockOut`=0, `abortCyc`=0, `restartCyc`=0.
- R2: A cycle runs from an accepted `cycStart` edge until the edge where `rdy` is sampled. With `holdReq` high, `holdAck` rises and both enables drop on the edge after the one where `rdy` ends the cycle, and never while a cycle is running.
- R3: `holdAck` is not given while `lockOut` or `lockReq` is high, even between the cycles of a locked sequence.
- R4: On the edge where `holdReq` is sampled low during acknowledge, `holdAck` drops and both enables return. A `cycStart` may be sampled from the next edge on.
- R5: `addrOe` drops on the edge where `addrHoldReq` is sampled high and returns on the edge where it is sampled low. `ctrlOe` is not affected, and a running cycle still completes on `rdy`.
- R6: On an edge where `backoffReq` is sampled high, both enables drop. If a cycle is running or starting on that edge, `abortCyc` pulses for one clock, even if `rdy` is sampled on the same edge.
- R7: `restartCyc` pulses on the first edge where `backoffReq` is sampled low, with the aborted cycle's address, byte enables and direction on `restartAddr`, `restartBe` and `restartWrite`. The restarted cycle then counts as running.
- R8: While `wbPending` is high, a pending restart is held back. It fires on the first edge with `backoffReq` low, `wbPending` low and no cycle running.
- R9: `lockOut` follows `lockReq` one edge later. After `lockOut` falls, it stays low for at least one further clock.
- R10: Backoff has priority over hold, and hold over address-hold: `backoffReq` forces the backoff state even during acknowledge, and `holdAck` removes both enables whatever `addrHoldReq` is.
- R11: `cycStart` sampled while the bus is not owned (acknowledge or backoff), or while a restart is pending, is ignored. It starts no cycle, and no abort or restart results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| holdReq | input | 1 | Full bus hold request |
| addrHoldReq | input | 1 | Address-only hold request |
| backoffReq | input | 1 | Immediate backoff request |
| cycStart | input | 1 | Cycle-start strobe from the sequencer |
| cycAddr | input | ADDR_W | Address of the cycle being started |
| cycBe | input | BE_W | Byte enables of the cycle being started |
| cycWrite | input | 1 | Direction of the cycle being started (1 = write) |
| rdy | input | 1 | Last ready of the running cycle |
| lockReq | input | 1 | Sequencer request to hold the bus locked |
| wbPending | input | 1 | Snoop writeback still to be performed |
| addrOe | output | 1 | Enable for address and address parity drivers |
| ctrlOe | output | 1 | Enable for all other bus drivers, lock included |
| holdAck | output | 1 | Hold acknowledge |
| lockOut | output | 1 | Bus lock |
| abortCyc | output | 1 | One-clock pulse: running cycle aborted |
| restartCyc | output | 1 | One-clock pulse: replay the aborted cycle |
| restartAddr | output | ADDR_W | Address of the cycle to replay |
| restartBe | output | BE_W | Byte enables of the cycle to replay |
| restartWrite | output | 1 | Direction of the cycle to replay |

## Verification
Every output is a register, so each result is due on the first rising edge after the edge where the inputs that cause it are sampled. The only longer delay is the acknowledge, which comes one edge after the ready that ends the cycle. The bench drives inputs on the falling edge and advances a reference model once per rising edge. It compares all outputs on the following falling edge, so every check samples exactly one edge after its stimulus. Directed sequences place ready, backoff, lock and writeback on the edges that the requirements single out.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [1:0] {
    ST_OWN    = 2'd0,
    ST_HOLDAK = 2'd1,
    ST_BACKOF = 2'd2
  } ownState_t;

  typedef struct packed {
    logic accept;      // cycle start taken, capture its attributes
    logic abortSave;   // running cycle aborted, save it for replay
    logic abortFromIn; // aborted cycle started on this very edge
    logic fire;        // replay of saved cycle issued
  } dpStrobe_t;

endpackage

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       holdReq,
  input  logic       addrHoldReq,
  input  logic       backoffReq,
  input  logic       cycStart,
  input  logic       rdy,
  input  logic       lockReq,
  input  logic       wbPending,
  output dpStrobe_t  strobe,
  output logic       addrOe,
  output logic       ctrlOe,
  output logic       holdAck,
  output logic       lockOut,
  output logic       abortCyc,
  output logic       restartCyc
);

  ownState_t stateQ, stateD;
  logic cycBusyQ, cycBusyD;
  logic pendQ, pendD;
  logic lockQ, gapQ;
  logic addrFloatQ;
  logic abortQ, restartQ;
  logic accept, abortNow, fire, holdOk;

  always_comb begin
    accept   = cycStart && (stateQ == ST_OWN) && !cycBusyQ && !pendQ;
    abortNow = backoffReq && (stateQ == ST_OWN) && (cycBusyQ || accept);
    fire     = !backoffReq && pendQ && !wbPending && !cycBusyQ && (stateQ != ST_HOLDAK);
    holdOk   = holdReq && !cycBusyQ && !accept && !lockQ && !lockReq && !pendQ;

    stateD = stateQ;
    if (backoffReq) begin
      stateD = ST_BACKOF;
    end else begin
      unique case (stateQ)
        ST_OWN:    if (holdOk) stateD = ST_HOLDAK;
        ST_HOLDAK: if (!holdReq) stateD = ST_OWN;
        ST_BACKOF: stateD = ST_OWN;
        default:   stateD = ST_OWN;
      endcase
    end

    if (backoffReq)            cycBusyD = 1'b0;
    else if (fire || accept)   cycBusyD = 1'b1;
    else if (cycBusyQ && rdy)  cycBusyD = 1'b0;
    else                       cycBusyD = cycBusyQ;

    if (abortNow)  pendD = 1'b1;
    else if (fire) pendD = 1'b0;
    else           pendD = pendQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ     <= ST_OWN;
      cycBusyQ   <= 1'b0;
      pendQ      <= 1'b0;
      lockQ      <= 1'b0;
      gapQ       <= 1'b0;
      addrFloatQ <= 1'b0;
      abortQ     <= 1'b0;
      restartQ   <= 1'b0;
    end else begin
      stateQ     <= stateD;
      cycBusyQ   <= cycBusyD;
      pendQ      <= pendD;
      lockQ      <= lockReq && !gapQ;
      gapQ       <= lockQ && !lockReq;
      addrFloatQ <= addrHoldReq;
      abortQ     <= abortNow;
      restartQ   <= fire;
    end
  end

  assign strobe.accept      = accept;
  assign strobe.abortSave   = abortNow;
  assign strobe.abortFromIn = abortNow && accept;
  assign strobe.fire        = fire;

  assign ctrlOe     = (stateQ == ST_OWN);
  assign addrOe     = (stateQ == ST_OWN) && !addrFloatQ;
  assign holdAck    = (stateQ == ST_HOLDAK);
  assign lockOut    = lockQ;
  assign abortCyc   = abortQ;
  assign restartCyc = restartQ;

  // R2 / R3: acknowledge only granted from a quiet, unlocked bus
  a_r2_ack_after_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(holdAck) |-> $past(!cycBusyQ && !lockQ));

  // R6: backoff removes every driver on the next edge
  a_r6_backoff_floats: assert property (@(posedge clk) disable iff (rst)
    backoffReq |=> (!ctrlOe && !addrOe));

  // R4: released hold drops acknowledge on the next edge
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (holdAck && !holdReq && !backoffReq) |=> !holdAck);

  // R9: one clear clock between locked sequences
  a_r9_lock_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(lockOut) |=> !lockOut);

  // R5: address-only hold leaves control drivers alone
  a_r5_addr_only: assert property (@(posedge clk) disable iff (rst)
    (addrHoldReq && ctrlOe && !backoffReq && !holdReq) |=> (!addrOe && ctrlOe));

  // R8: no replay while a writeback is outstanding
  a_r8_wb_first: assert property (@(posedge clk) disable iff (rst)
    wbPending |=> !restartCyc);

endmodule

// File: rtl/bus_own_dp.sv
module bus_own_dp
  import bus_own_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int BE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [BE_W-1:0]   cycBe,
  input  logic              cycWrite,
  output logic [ADDR_W-1:0] restartAddr,
  output logic [BE_W-1:0]   restartBe,
  output logic              restartWrite
);

  localparam int REC_W = ADDR_W + BE_W + 1;

  logic [REC_W-1:0] inRec, curRec, savRec;

  assign inRec = {cycAddr, cycBe, cycWrite};

  always_ff @(posedge clk) begin
    if (rst) begin
      curRec <= '0;
      savRec <= '0;
    end else begin
      if (strobe.accept)    curRec <= inRec;
      else if (strobe.fire) curRec <= savRec;
      if (strobe.abortSave) savRec <= strobe.abortFromIn ? inRec : curRec;
    end
  end

  assign {restartAddr, restartBe, restartWrite} = savRec;

  // R7: replay record is frozen while it is being replayed
  a_r7_rec_stable: assert property (@(posedge clk) disable iff (rst)
    (strobe.fire && !strobe.abortSave) |=> $stable(savRec));

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int BE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              holdReq,
  input  logic              addrHoldReq,
  input  logic              backoffReq,
  input  logic              cycStart,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [BE_W-1:0]   cycBe,
  input  logic              cycWrite,
  input  logic              rdy,
  input  logic              lockReq,
  input  logic              wbPending,
  output logic              addrOe,
  output logic              ctrlOe,
  output logic              holdAck,
  output logic              lockOut,
  output logic              abortCyc,
  output logic              restartCyc,
  output logic [ADDR_W-1:0] restartAddr,
  output logic [BE_W-1:0]   restartBe,
  output logic              restartWrite
);

  dpStrobe_t strobe;

  bus_own_fsm u_fsm (
    .clk(clk), .rst(rst), .holdReq(holdReq), .addrHoldReq(addrHoldReq),
    .backoffReq(backoffReq), .cycStart(cycStart), .rdy(rdy),
    .lockReq(lockReq), .wbPending(wbPending), .strobe(strobe),
    .addrOe(addrOe), .ctrlOe(ctrlOe), .holdAck(holdAck), .lockOut(lockOut),
    .abortCyc(abortCyc), .restartCyc(restartCyc)
  );

  bus_own_dp #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cycAddr(cycAddr),
    .cycBe(cycBe), .cycWrite(cycWrite), .restartAddr(restartAddr),
    .restartBe(restartBe), .restartWrite(restartWrite)
  );

  // R10: acknowledge and address drive never coexist
  a_r10_ack_floats_all: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> (!addrOe && !ctrlOe));

endmodule

// File: tb/bus_own_ctrl_tb.sv
module bus_own_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 29;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic holdReq = 0, addrHoldReq = 0, backoffReq = 0, cycStart = 0;
  logic [AW-1:0] cycAddr = '0;
  logic [BW-1:0] cycBe = '0;
  logic cycWrite = 0, rdy = 0, lockReq = 0, wbPending = 0;
  logic addrOe, ctrlOe, holdAck, lockOut, abortCyc, restartCyc, restartWrite;
  logic [AW-1:0] restartAddr;
  logic [BW-1:0] restartBe;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_own_ctrl #(.ADDR_W(AW), .BE_W(BW)) u_dut (
    .clk(clk), .rst(rst), .holdReq(holdReq), .addrHoldReq(addrHoldReq),
    .backoffReq(backoffReq), .cycStart(cycStart), .cycAddr(cycAddr),
    .cycBe(cycBe), .cycWrite(cycWrite), .rdy(rdy), .lockReq(lockReq),
    .wbPending(wbPending), .addrOe(addrOe), .ctrlOe(ctrlOe),
    .holdAck(holdAck), .lockOut(lockOut), .abortCyc(abortCyc),
    .restartCyc(restartCyc), .restartAddr(restartAddr),
    .restartBe(restartBe), .restartWrite(restartWrite)
  );

  // reference model state: 0 own, 1 acknowledged hold, 2 backed off
  int mSt;
  bit mBusy, mPend, mLock, mGap, mFloat, mAbort, mRestart;
  logic [AW+BW:0] mCur, mSav;

  function automatic bit expAddrOe(); return (mSt == 0) && !mFloat; endfunction
  function automatic bit expCtrlOe(); return mSt == 0; endfunction

  task automatic modelReset();
    mSt = 0; mBusy = 0; mPend = 0; mLock = 0; mGap = 0; mFloat = 0;
    mAbort = 0; mRestart = 0; mCur = '0; mSav = '0;
  endtask

  task automatic modelStep();
    bit acc, abt, fire, hok;
    int nst;
    logic [AW+BW:0] inRec;
    inRec = {cycAddr, cycBe, cycWrite};
    acc  = cycStart && mSt == 0 && !mBusy && !mPend;
    abt  = backoffReq && mSt == 0 && (mBusy || acc);
    fire = !backoffReq && mPend && !wbPending && !mBusy && mSt != 1;
    hok  = holdReq && !mBusy && !acc && !mLock && !lockReq && !mPend;
    nst = mSt;
    if (backoffReq) nst = 2;
    else if (mSt == 0 && hok) nst = 1;
    else if (mSt == 1 && !holdReq) nst = 0;
    else if (mSt == 2) nst = 0;
    if (abt) mSav = acc ? inRec : mCur;
    if (acc) mCur = inRec;
    else if (fire) mCur = mSav;
    if (backoffReq) mBusy = 0;
    else if (fire || acc) mBusy = 1;
    else if (mBusy && rdy) mBusy = 0;
    if (abt) mPend = 1; else if (fire) mPend = 0;
    mGap = mLock && !lockReq;
    mLock = lockReq && !(mGap && 1'b0) && !gapPrev;
    mFloat = addrHoldReq;
    mAbort = abt; mRestart = fire; mSt = nst;
  endtask

  // gap register of the model, kept apart so the lock update sees the old value
  bit gapPrev;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "addrOe", addrOe, expAddrOe());
    chk(tag, "ctrlOe", ctrlOe, expCtrlOe());
    chk(tag, "holdAck", holdAck, mSt == 1);
    chk(tag, "lockOut", lockOut, mLock);
    chk(tag, "abortCyc", abortCyc, mAbort);
    chk(tag, "restartCyc", restartCyc, mRestart);
    if (mRestart) chk(tag, "restartRec", {restartAddr, restartBe, restartWrite}, mSav);
  endtask

  // one clock: inputs already set at a falling edge; step on rising, check on falling
  task automatic tick(string tag);
    bit oldGap;
    @(posedge clk);
    oldGap = gapPrev;
    gapPrev = mLock && !lockReq;
    modelStepWithGap(oldGap);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic modelStepWithGap(bit oldGap);
    bit keepLock;
    keepLock = lockReq && !oldGap;
    modelStep();
    mLock = keepLock;
  endtask

  task automatic idleIns();
    holdReq = 0; addrHoldReq = 0; backoffReq = 0; cycStart = 0;
    rdy = 0; lockReq = 0; wbPending = 0;
  endtask

  task automatic startCyc(logic [AW-1:0] a, logic [BW-1:0] b, logic w);
    cycStart = 1; cycAddr = a; cycBe = b; cycWrite = w;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    modelReset(); gapPrev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    chk("R1", "addrOe", addrOe, 1); chk("R1", "ctrlOe", ctrlOe, 1);
    chk("R1", "holdAck", holdAck, 0); chk("R1", "lockOut", lockOut, 0);
    chk("R1", "abortCyc", abortCyc, 0); chk("R1", "restartCyc", restartCyc, 0);

    // R2: hold during a cycle, ready on third edge, ack one edge later
    startCyc(29'h123, 8'hF0, 1); holdReq = 1; tick("R2");
    cycStart = 0; tick("R2"); tick("R2");
    rdy = 1; tick("R2");
    chk("R2", "noAckOnRdyEdge", holdAck, 0);
    rdy = 0; tick("R2");
    chk("R2", "ackAfterRdy", holdAck, 1);
    // R10: address-hold during acknowledge leaves all floated
    addrHoldReq = 1; tick("R10"); chk("R10", "addrOeFloat", addrOe, 0);
    // R11: start ignored while acknowledged
    startCyc(29'h7, 8'h01, 0); tick("R11"); cycStart = 0;
    // R4: release
    addrHoldReq = 0; holdReq = 0; tick("R4");
    chk("R4", "ackDropped", holdAck, 0); chk("R4", "ctrlBack", ctrlOe, 1);

    // R3: locked pair blocks hold between cycles
    lockReq = 1; startCyc(29'h40, 8'hFF, 0); tick("R3");
    cycStart = 0; rdy = 1; holdReq = 1; tick("R3");
    rdy = 0; tick("R3"); chk("R3", "noAckInLock", holdAck, 0);
    startCyc(29'h40, 8'hFF, 1); tick("R3"); cycStart = 0; rdy = 1; tick("R3");
    rdy = 0; lockReq = 0; tick("R3"); tick("R3");
    chk("R3", "ackAfterLock", holdAck, 1);
    holdReq = 0; tick("R4");

    // R9: lock gap
    lockReq = 1; tick("R9"); tick("R9"); lockReq = 0; tick("R9");
    lockReq = 1; tick("R9"); chk("R9", "gapHeld", lockOut, 0);
    tick("R9"); chk("R9", "lockAgain", lockOut, 1); lockReq = 0; tick("R9"); tick("R9");

    // R5: address-only hold during a running cycle
    startCyc(29'h1ABCDEF, 8'h0F, 1); tick("R5"); cycStart = 0;
    addrHoldReq = 1; tick("R5"); chk("R5", "addrFloat", addrOe, 0);
    chk("R5", "ctrlKept", ctrlOe, 1);
    rdy = 1; tick("R5"); rdy = 0; addrHoldReq = 0; tick("R5");
    chk("R5", "addrBack", addrOe, 1);

    // R6 / R7: backoff with ready on same edge, replay on release
    startCyc(29'h0BEEF, 8'h3C, 0); tick("R6"); cycStart = 0;
    rdy = 1; backoffReq = 1; tick("R6");
    chk("R6", "abortPulse", abortCyc, 1); chk("R6", "ctrlFloat", ctrlOe, 0);
    rdy = 0; tick("R6"); backoffReq = 0; tick("R7");
    chk("R7", "restartPulse", restartCyc, 1);
    chk("R7", "restartAddr", restartAddr, 29'h0BEEF);
    chk("R7", "restartBe", restartBe, 8'h3C);
    rdy = 1; tick("R7"); rdy = 0;

    // R8: writeback pending delays restart; R10 backoff beats hold
    startCyc(29'h55, 8'hAA, 1); holdReq = 1; backoffReq = 1; wbPending = 1; tick("R10");
    chk("R10", "backoffWins", holdAck, 0); cycStart = 0;
    backoffReq = 0; holdReq = 0; tick("R8"); chk("R8", "heldBack", restartCyc, 0);
    tick("R8"); wbPending = 0; tick("R8");
    chk("R8", "restartAfterWb", restartCyc, 1);
    chk("R8", "restartWrite", restartWrite, 1);
    rdy = 1; tick("R8"); rdy = 0;

    // R11: start during backoff yields no abort or replay
    backoffReq = 1; tick("R11"); startCyc(29'h9, 8'h1, 0); tick("R11");
    cycStart = 0; backoffReq = 0; tick("R11");
    chk("R11", "noReplay", restartCyc, 0);
    idleIns(); tick("R11");

    // constrained random mix checked against the model
    for (int i = 0; i < 4000; i++) begin
      holdReq     = ($urandom_range(0, 9) < 2);
      addrHoldReq = ($urandom_range(0, 9) < 3);
      backoffReq  = ($urandom_range(0, 19) < 2);
      cycStart    = ($urandom_range(0, 3) == 0);
      cycAddr     = AW'($urandom);
      cycBe       = BW'($urandom);
      cycWrite    = $urandom_range(0, 1);
      rdy         = ($urandom_range(0, 2) == 0);
      lockReq     = ($urandom_range(0, 9) < 3) ? ~lockReq : lockReq;
      wbPending   = ($urandom_range(0, 9) < 2) ? ~wbPending : wbPending;
      tick("R2-mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule